// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for a stalled program. Once enabled, it counts an interrupt interval. When that interval runs out, a sticky expiry flag is set and an interrupt can be raised. A second interval, the reset stage, then begins. If software still has not serviced the timer when the reset stage ends, the block raises a reset request for the system reset logic. Software services the timer by writing a fixed key to the restart register.

Both interval lengths are powers of two. Each is chosen by a code field in the control register. The timer counts either every bus clock cycle or only on cycles where an external tick enable is high. The external tick is assumed to be already synchronous to the bus clock.

A stray write cannot disable or restart the timer. The control register and the restart register accept a write only right after a separate unlock register has received its own key. Each unlock is good for one such write.

Top module: `wdt_two_stage`

## Requirements
- R1: After synchronous reset, the control register is 0, the expiry flag is 0, and `irq`, `reset_req` and `bus_rdata` are all 0.
- R2: The register map is control at 0x10, restart at 0x14, unlock at 0x18 and status at 0x1C. Control fields are bit0 enable, bit1 clock select, bit2 interrupt enable, bit3 reset enable, bits 7:4 interrupt code and bits 10:8 reset code. Status bit0 is the expiry flag. `bus_rdata` is registered and shows the addressed register one cycle after the address is presented. Control reads back its 11 bits, status reads back bit0, and every other offset reads 0.
- R3: A write to control or restart takes effect only if the write just before it on the bus, of those to these three registers, was to unlock with 0x5AA5 in bits 15:0. Exactly one control or restart write consumes the unlock, and a later write is ignored again. An unlock write with any other value cancels the unlock.
- R4: Interrupt code c gives a length in counting ticks of 2^6, 2^8, 2^10, 2^11, 2^12, 2^13, 2^14, 2^15, 2^17, 2^19, 2^21, 2^23, 2^25, 2^27, 2^29 or 2^31 for c = 0 to 15. The expiry flag is set on the tick that completes this length, counted from the write that enables the timer or from the last valid restart.
- R5: After the interrupt stage expires, the reset stage lasts 2^(7+n) ticks, where n is the reset code. When it completes, the block enters a done state that holds until a restart or a disable.
- R6: `reset_req` is high exactly while the block is in the done state and reset enable (bit3) is set. Setting the reset enable while in the done state raises `reset_req`.
- R7: `irq` is high exactly while the expiry flag and the interrupt enable (bit2) are both set.
- R8: Writing status with bit0 = 1 clears the expiry flag, and writing 0 leaves it unchanged. Status writes need no unlock.
- R9: An unlocked write of 0xCAFE in bits 15:0 to restart clears the count, returns the block to the interrupt stage and drops `reset_req`. The expiry flag is left as it is. A restart write with another value changes nothing.
- R10: While enable (bit0) is 0, the count is held at zero in the interrupt stage and `reset_req` is low. Enabling the timer starts a full interrupt interval.
- R11: With clock select at 1, every cycle is a counting tick. With clock select at 0, only cycles with `ext_tick` high are counting ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W (32) | Registered read data for the previous cycle's address |
| ext_tick | input | 1 | Synchronous counting enable used when clock select is 0 |
| irq | output | 1 | Interrupt, expiry flag gated by interrupt enable |
| reset_req | output | 1 | Watchdog reset request |

## Verification
The bench uses the default 32-bit counter, but it programs only the short codes: interrupt codes 0 to 3 (64 to 2048 ticks) and reset codes 0 to 2 (128 to 512 ticks). All twelve combinations of these codes are swept, and for each one the bench checks the exact cycles just before and at both expiries. Because the intervals are this short, it is practical to test restart with a bad key, restart in the reset stage and in the done state, locked writes, disable during counting, and counting on a half-rate external tick against cycle counts the bench works out itself.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned OFS_CTRL    = 'h10;
  localparam int unsigned OFS_RESTART = 'h14;
  localparam int unsigned OFS_UNLOCK  = 'h18;
  localparam int unsigned OFS_STATUS  = 'h1C;

  localparam logic [15:0] KEY_RESTART = 16'hCAFE;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5AA5;

  typedef enum logic [1:0] {
    STG_INT  = 2'd0,
    STG_RST  = 2'd1,
    STG_DONE = 2'd2
  } stage_e;

  // MSB first: bits 10:8 reset code ... bit0 enable
  typedef struct packed {
    logic [2:0] rst_code;
    logic [3:0] int_code;
    logic       rst_en;
    logic       int_en;
    logic       clk_sel;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // exponent of the interrupt-stage length for a 4-bit code
  function automatic int unsigned int_exp(input logic [3:0] code);
    if (code < 4'd2)      return 6 + 2 * int'(code);
    else if (code < 4'd8) return int'(code) + 8;
    else                  return 2 * int'(code) + 1;
  endfunction

  function automatic int unsigned rst_exp(input logic [2:0] code);
    return 7 + int'(code);
  endfunction

endpackage

// File: rtl/wdt_interval.sv
module wdt_interval
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  ctrl_t             ctrl,
  output logic [CNT_W-1:0]  int_last,
  output logic [CNT_W-1:0]  rst_last
);

  localparam int N_INT = 16;
  localparam int N_RST = 8;

  logic [CNT_W-1:0] int_tab [N_INT];
  logic [CNT_W-1:0] rst_tab [N_RST];

  for (genvar g = 0; g < N_INT; g++) begin : g_int
    assign int_tab[g] = CNT_W'((64'd1 << int_exp(4'(g))) - 64'd1);
  end

  for (genvar g = 0; g < N_RST; g++) begin : g_rst
    assign rst_tab[g] = CNT_W'((64'd1 << rst_exp(3'(g))) - 64'd1);
  end

  assign int_last = int_tab[ctrl.int_code];
  assign rst_last = rst_tab[ctrl.rst_code];

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             restart,
  input  logic             ext_tick,
  input  logic [CNT_W-1:0] int_last,
  input  logic [CNT_W-1:0] rst_last,
  output logic [CNT_W-1:0] cnt_q,
  output stage_e           stage_q,
  output logic             int_expire
);

  logic run;
  logic rst_expire;

  always_comb begin
    run        = ctrl.en & ~restart & (ctrl.clk_sel | ext_tick);
    int_expire = run && (stage_q == STG_INT) && (cnt_q >= int_last);
    rst_expire = run && (stage_q == STG_RST) && (cnt_q >= rst_last);
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.en || restart) begin
      cnt_q   <= '0;
      stage_q <= STG_INT;
    end else if (int_expire) begin
      cnt_q   <= '0;
      stage_q <= STG_RST;
    end else if (rst_expire) begin
      cnt_q   <= '0;
      stage_q <= STG_DONE;
    end else if (run && stage_q != STG_DONE) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              int_expire,
  output ctrl_t             ctrl_q,
  output logic              status_q,
  output logic              unlock_q,
  output logic              restart_fire,
  output logic [DATA_W-1:0] bus_rdata
);

  logic hit_ctrl, hit_rst, hit_unl, hit_st;
  logic unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:16];

  always_comb begin
    hit_ctrl     = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    hit_rst      = bus_we && (bus_addr == ADDR_W'(OFS_RESTART));
    hit_unl      = bus_we && (bus_addr == ADDR_W'(OFS_UNLOCK));
    hit_st       = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
    restart_fire = hit_rst && unlock_q && (bus_wdata[15:0] == KEY_RESTART);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      unlock_q <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (hit_ctrl && unlock_q)
        ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (hit_unl)
        unlock_q <= (bus_wdata[15:0] == KEY_UNLOCK);
      else if (hit_ctrl || hit_rst)
        unlock_q <= 1'b0;
      if (int_expire)
        status_q <= 1'b1;
      else if (hit_st && bus_wdata[0])
        status_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata <= DATA_W'(ctrl_q);
    end else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
      bus_rdata <= DATA_W'(status_q);
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_tick,
  output logic              irq,
  output logic              reset_req
);

  ctrl_t            ctrl_q;
  logic             status_q;
  logic             unlock_q;
  logic             restart_fire;
  logic             int_expire;
  logic [CNT_W-1:0] int_last;
  logic [CNT_W-1:0] rst_last;
  logic [CNT_W-1:0] cnt_q;
  stage_e           stage_q;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .int_expire   (int_expire),
    .ctrl_q       (ctrl_q),
    .status_q     (status_q),
    .unlock_q     (unlock_q),
    .restart_fire (restart_fire),
    .bus_rdata    (bus_rdata)
  );

  wdt_interval #(.CNT_W(CNT_W)) u_interval (
    .ctrl     (ctrl_q),
    .int_last (int_last),
    .rst_last (rst_last)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .restart    (restart_fire),
    .ext_tick   (ext_tick),
    .int_last   (int_last),
    .rst_last   (rst_last),
    .cnt_q      (cnt_q),
    .stage_q    (stage_q),
    .int_expire (int_expire)
  );

  // both outputs are gates of flop outputs only
  assign irq       = status_q & ctrl_q.int_en;
  assign reset_req = (stage_q == STG_DONE) & ctrl_q.rst_en;

endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              ext_tick,
  input ctrl_t             ctrl_q,
  input logic              status_q,
  input logic              unlock_q,
  input logic              restart_fire,
  input logic [CNT_W-1:0]  cnt_q,
  input stage_e            stage_q,
  input logic              reset_req
);

  // R10
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.en |=> (cnt_q == '0) && !reset_req);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status_q && !(bus_we && bus_addr == ADDR_W'(OFS_STATUS) && bus_wdata[0]) |=> status_q);

  // R4
  flag_from_int_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(stage_q) == STG_INT);

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    restart_fire |=> (cnt_q == '0) && (stage_q == STG_INT) && !reset_req);

  // R3
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    !unlock_q && bus_we && bus_addr == ADDR_W'(OFS_CTRL) |=> $stable(ctrl_q));

  // R11
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q.en && !ctrl_q.clk_sel && !ext_tick && !bus_we |=> $stable(cnt_q) && $stable(stage_q));

endmodule

bind wdt_two_stage wdt_two_stage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_we       (bus_we),
  .ext_tick     (ext_tick),
  .ctrl_q       (ctrl_q),
  .status_q     (status_q),
  .unlock_q     (unlock_q),
  .restart_fire (restart_fire),
  .cnt_q        (cnt_q),
  .stage_q      (stage_q),
  .reset_req    (reset_req)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;

  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_RST  = 8'h14;
  localparam logic [7:0] A_UNL  = 8'h18;
  localparam logic [7:0] A_ST   = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic        irq;
  logic        reset_req;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_two_stage u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .ext_tick  (ext_tick),
    .irq       (irq),
    .reset_req (reset_req)
  );

  function automatic int int_len_exp(input int c);
    case (c)
      0: return 6;   1: return 8;   2: return 10;  3: return 11;
      4: return 12;  5: return 13;  6: return 14;  7: return 15;
      8: return 17;  9: return 19;  10: return 21; 11: return 23;
      12: return 25; 13: return 27; 14: return 29; default: return 31;
    endcase
  endfunction

  function automatic logic [31:0] cfg(input bit en, input bit cs, input bit ie,
                                      input bit re, input int ic, input int rc);
    return {21'b0, 3'(rc), 4'(ic), re, ie, cs, en};
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic prot_wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr(A_UNL, 32'h5AA5);
    bus_wr(a, d);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int t0, t1, t2, L, R;

    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 reset_req", 32'(reset_req), 0);
    chk("R1 rdata", bus_rdata, 0);
    bus_rd(A_CTRL, rd); chk("R1 ctrl", rd, 0);
    bus_rd(A_ST, rd);   chk("R1 status", rd, 0);

    // R2 reserved and write-only offsets read zero
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, rd); chk("R2 reserved 04", rd, 0);
    bus_rd(8'h0C, rd); chk("R2 reserved 0C", rd, 0);
    bus_rd(A_RST, rd); chk("R2 restart reads 0", rd, 0);
    bus_rd(A_UNL, rd); chk("R2 unlock reads 0", rd, 0);

    // R3 protection
    bus_wr(A_CTRL, 32'h7FE);
    bus_rd(A_CTRL, rd); chk("R3 locked ctrl write", rd, 0);
    prot_wr(A_CTRL, 32'hFFFF_F3F6);
    bus_rd(A_CTRL, rd); chk("R2 ctrl readback 11 bits", rd, 32'h3F6);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, rd); chk("R3 unlock one-shot", rd, 32'h3F6);
    bus_wr(A_UNL, 32'h1234);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, rd); chk("R3 bad unlock key", rd, 32'h3F6);
    prot_wr(A_CTRL, 32'h0);

    // R4 R5 sweep of short codes
    for (int ic = 0; ic < 4; ic++) begin
      for (int rc = 0; rc < 3; rc++) begin
        prot_wr(A_CTRL, 32'h0);
        bus_wr(A_ST, 32'h1);
        prot_wr(A_CTRL, cfg(1, 1, 1, 1, ic, rc));
        t0 = cyc;
        L = 1 << int_len_exp(ic);
        R = 1 << (7 + rc);
        wait_until(t0 + L - 1); chk($sformatf("R4 ic%0d before", ic), 32'(irq), 0);
        wait_until(t0 + L);     chk($sformatf("R4 ic%0d at", ic), 32'(irq), 1);
        wait_until(t0 + L + R - 1); chk($sformatf("R5 rc%0d before", rc), 32'(reset_req), 0);
        wait_until(t0 + L + R);     chk($sformatf("R5 rc%0d at", rc), 32'(reset_req), 1);
      end
    end

    // R8 write-1-to-clear
    bus_rd(A_ST, rd); chk("R2 status set", rd, 1);
    bus_wr(A_ST, 32'h0);
    bus_rd(A_ST, rd); chk("R8 write 0 no effect", rd, 1);
    bus_wr(A_ST, 32'h1);
    bus_rd(A_ST, rd); chk("R8 write 1 clears", rd, 0);
    chk("R7 irq follows flag", 32'(irq), 0);
    chk("R6 done still requests", 32'(reset_req), 1);

    // R10 disable drops request
    prot_wr(A_CTRL, 32'h0);
    chk("R10 disable drops req", 32'(reset_req), 0);

    // R7 mask, R6 late reset enable
    prot_wr(A_CTRL, cfg(1, 1, 0, 0, 0, 0));
    t0 = cyc;
    wait_until(t0 + 70);
    chk("R7 masked irq", 32'(irq), 0);
    bus_rd(A_ST, rd); chk("R7 flag set while masked", rd, 1);
    prot_wr(A_CTRL, cfg(1, 1, 1, 0, 0, 0));
    chk("R7 unmask raises irq", 32'(irq), 1);
    wait_until(t0 + 64 + 128 + 10);
    chk("R6 no req without enable", 32'(reset_req), 0);
    prot_wr(A_CTRL, cfg(1, 1, 1, 1, 0, 0));
    chk("R6 late enable raises req", 32'(reset_req), 1);

    // R10 disable mid-count holds count
    prot_wr(A_CTRL, 32'h0);
    bus_wr(A_ST, 32'h1);
    prot_wr(A_CTRL, cfg(1, 1, 1, 1, 0, 0));
    idle(40);
    prot_wr(A_CTRL, cfg(0, 1, 1, 1, 0, 0));
    idle(300);
    chk("R10 no expiry while disabled", 32'(irq), 0);
    prot_wr(A_CTRL, cfg(1, 1, 1, 1, 0, 0));
    t0 = cyc;
    wait_until(t0 + 63); chk("R10 full interval before", 32'(irq), 0);
    wait_until(t0 + 64); chk("R10 full interval at", 32'(irq), 1);

    // R9 restart
    prot_wr(A_CTRL, 32'h0);
    bus_wr(A_ST, 32'h1);
    prot_wr(A_CTRL, cfg(1, 1, 1, 1, 0, 0));
    t0 = cyc;
    wait_until(t0 + 40);
    prot_wr(A_RST, 32'hBEEF);
    wait_until(t0 + 63); chk("R9 bad key before", 32'(irq), 0);
    wait_until(t0 + 64); chk("R9 bad key ignored", 32'(irq), 1);
    wait_until(t0 + 100);
    prot_wr(A_RST, 32'hCAFE);
    t1 = cyc;
    chk("R9 flag kept", 32'(irq), 1);
    wait_until(t1 + 191); chk("R9 req before", 32'(reset_req), 0);
    wait_until(t1 + 192); chk("R9 req at", 32'(reset_req), 1);
    prot_wr(A_RST, 32'hCAFE);
    t2 = cyc;
    chk("R9 restart in done drops req", 32'(reset_req), 0);
    wait_until(t2 + 50);
    bus_wr(A_RST, 32'hCAFE);
    wait_until(t2 + 191); chk("R3 locked restart before", 32'(reset_req), 0);
    wait_until(t2 + 192); chk("R3 locked restart ignored", 32'(reset_req), 1);

    // R11 external tick
    prot_wr(A_CTRL, 32'h0);
    bus_wr(A_ST, 32'h1);
    ext_tick = 1'b0;
    prot_wr(A_CTRL, cfg(1, 0, 1, 1, 0, 0));
    idle(300);
    chk("R11 no ticks no count", 32'(irq), 0);
    for (int k = 0; k < 128; k++) begin
      ext_tick = (k % 2 == 0);
      @(posedge clk); @(negedge clk);
      if (k == 125) chk("R11 63 ticks", 32'(irq), 0);
      if (k == 126) chk("R11 64 ticks", 32'(irq), 1);
    end
    ext_tick = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule